// File: doc/BRIEF.md
# Synthesizer Control Latch and Power-Down Sequencer

This block is the digital front end of an integer-N frequency synthesizer. Software programs it through a three-wire serial port made up of a serial clock, serial data and a load strobe. The block keeps the most recent 24 bits that were shifted in. On the rising edge of the load strobe it files the word into one of four registers, chosen by the word's two lowest bits. Code 00 selects the control register. The block decodes that register into the control outputs seen by the charge pump, the VCO, the divider counters and the lock detector. The other three registers are only stored, and their payloads are presented on a single bus.

A small state machine sequences power-down. It has four states:
- `PD_RUN`: normal operation.
- `PD_ARM1`: a synchronous request is waiting for its first reference-divider edge.
- `PD_ARM2`: the request is waiting for the second edge.
- `PD_DOWN`: powered down.

The transitions are:
- Any control write with the power-down bit (bit 20) clear goes to `PD_RUN`.
- A control write with bit 20 set and the mode bit (bit 21) clear goes to `PD_DOWN` (asynchronous request).
- A control write with both bits set goes to `PD_ARM1`. If the state is already `PD_DOWN`, it stays in `PD_DOWN`.
- Without a control write, a reference-divider edge moves `PD_ARM1` to `PD_ARM2` and moves `PD_ARM2` to `PD_DOWN`.
- A control write takes priority over a reference edge in the same cycle.

A chip-enable input, when low, forces the powered-down output state at once, whatever the state machine holds.

All inputs are sampled on the system clock. The serial clock, data and load strobe first pass through a synchronizer of `SYNC_STAGES` flops. The reference-divider pulse and the lock-detect input are taken as synchronous to the system clock.

Top module: `pll_ctl_top`

## Requirements
- R1: After reset, every register reads zero. A load places bits 23..2 of the word into the register selected by bits 1..0. Code 00 is the control register. Codes 1, 2 and 3 fill `aux_regs_o` slices [21:0], [43:22] and [65:44] respectively. No other register changes.
- R2: Serial data is shifted in MSB first on each rising serial-clock edge. Only the last 24 bits before the load strobe rises form the word, however many bits preceded them.
- R3: A control write with bit 20 = 1 and bit 21 = 0 enters power-down on the next system clock edge after the write is detected.
- R4: A control write with bit 20 = 1 and bit 21 = 1 enters power-down on the second rising edge of `ref_div_i` that follows the write, and not before.
- R5: A control write with bit 20 = 0 leaves power-down, or cancels a pending synchronous request, on the next clock edge. Reference edges that arrive after a cancel have no effect.
- R6: While `chip_en_i` is low, `pd_o` is high and every power-down side effect is active in the same cycle, regardless of bits 20 and 21.
- R7: While powered down, `cnt_load_o`, `ld_rst_o`, `cp_tri_o` and `pd_o` are high and `rf_en_o` is low.
- R8: While powered down, serial words continue to be shifted and loaded into the registers.
- R9: With control bit 11 set, `rf_en_o` stays low until `lock_det_i` is high.
- R10: `cp_cur_o` takes control bits 19..17 when control bit 10 is 1, and bits 16..14 when it is 0.
- R11: `cnt_rst_o` equals control bit 4.
- R12: `cp_tri_o` is the OR of control bit 9 and the power-down state.
- R13: `presc_o` carries control bits 23..22, `pdp_o` bit 8, `mux_sel_o` bits 7..5, `out_pwr_o` bits 13..12 and `core_cur_o` bits 3..2.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ser_clk_i | input | 1 | Serial shift clock |
| ser_dat_i | input | 1 | Serial data, MSB first |
| ser_le_i | input | 1 | Load strobe; its rising edge files the word |
| chip_en_i | input | 1 | Chip enable; low forces power-down |
| ref_div_i | input | 1 | Reference-divider output pulse |
| lock_det_i | input | 1 | Lock indication from the lock detector |
| presc_o | output | 2 | Prescaler select |
| cp_cur_o | output | 3 | Selected charge-pump current code |
| cp_tri_o | output | 1 | Charge pump three-state |
| pdp_o | output | 1 | Phase detector polarity |
| mux_sel_o | output | 3 | Test multiplexer select |
| cnt_rst_o | output | 1 | Holds the reference and feedback counters in reset |
| cnt_load_o | output | 1 | Forces the counters to their load state |
| ld_rst_o | output | 1 | Resets the digital lock detector |
| rf_en_o | output | 1 | RF output enable |
| pd_o | output | 1 | Power-down: removes bias from the analog blocks |
| out_pwr_o | output | 2 | RF output power level |
| core_cur_o | output | 2 | VCO core current level |
| aux_regs_o | output | 66 | Payloads of the registers at codes 3, 2, 1 (high to low) |

## Verification
A load strobe rise is registered by the state machine and the registers three system clocks later: two synchronizer stages plus one register stage. The bench holds the strobe high for six cycles and then waits three more before it samples, so every decoded output has settled. A reference pulse is seen by the state machine on the first clock edge after it is driven. The bench therefore checks the power-down outputs two cycles after each pulse. `chip_en_i` and `lock_det_i` act combinationally, and the bench samples them one cycle after it changes them. All sampling takes place on the falling clock edge, away from the edge at which the design updates.

// File: rtl/pll_ctl_pkg.sv
package pll_ctl_pkg;

    localparam int WORD_W = 24;
    localparam int ADDR_W = 2;
    localparam int PAY_W  = WORD_W - ADDR_W;
    localparam int N_REG  = 1 << ADDR_W;
    localparam int AUX_W  = (N_REG - 1) * PAY_W;

    // field widths
    localparam int PRESC_W = 2;
    localparam int CS_W    = 3;
    localparam int MUX_W   = 3;
    localparam int LVL_W   = 2;

    // bit positions in the 24-bit word
    localparam int B_PRESC_LO = 22;
    localparam int B_PD_MODE  = 21;
    localparam int B_PD_REQ   = 20;
    localparam int B_CS2_LO   = 17;
    localparam int B_CS1_LO   = 14;
    localparam int B_OPWR_LO  = 12;
    localparam int B_MUTE     = 11;
    localparam int B_GAIN     = 10;
    localparam int B_TRI      = 9;
    localparam int B_PDP      = 8;
    localparam int B_MUX_LO   = 5;
    localparam int B_CRST     = 4;
    localparam int B_CORE_LO  = 2;

    typedef enum logic [1:0] {
        PD_RUN  = 2'd0,
        PD_ARM1 = 2'd1,
        PD_ARM2 = 2'd2,
        PD_DOWN = 2'd3
    } pd_state_t;

endpackage

// File: rtl/pll_ser_rx.sv
module pll_ser_rx
    import pll_ctl_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ser_clk_i,
    input  logic              ser_dat_i,
    input  logic              ser_le_i,
    output logic [WORD_W-1:0] word_o,
    output logic              load_o
);

    logic [SYNC_STAGES-1:0] ck_s;
    logic [SYNC_STAGES-1:0] dt_s;
    logic [SYNC_STAGES-1:0] le_s;
    logic                   ck_q;
    logic                   le_q;
    logic [WORD_W-1:0]      shreg;
    logic                   ck_rise;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ck_s <= '0;
            dt_s <= '0;
            le_s <= '0;
            ck_q <= 1'b0;
            le_q <= 1'b0;
        end else begin
            ck_s <= {ck_s[SYNC_STAGES-2:0], ser_clk_i};
            dt_s <= {dt_s[SYNC_STAGES-2:0], ser_dat_i};
            le_s <= {le_s[SYNC_STAGES-2:0], ser_le_i};
            ck_q <= ck_s[SYNC_STAGES-1];
            le_q <= le_s[SYNC_STAGES-1];
        end
    end

    assign ck_rise = ck_s[SYNC_STAGES-1] && !ck_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            shreg <= '0;
        end else if (ck_rise) begin
            shreg <= {shreg[WORD_W-2:0], dt_s[SYNC_STAGES-1]};
        end
    end

    assign word_o = shreg;
    assign load_o = le_s[SYNC_STAGES-1] && !le_q;

endmodule

// File: rtl/pll_reg_bank.sv
module pll_reg_bank
    import pll_ctl_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load_i,
    input  logic [WORD_W-1:0] word_i,
    output logic [PAY_W-1:0]  ctl_o,
    output logic [AUX_W-1:0]  aux_o
);

    logic [ADDR_W-1:0] addr;
    assign addr = word_i[ADDR_W-1:0];

    for (genvar k = 0; k < N_REG; k++) begin : g_reg
        logic [PAY_W-1:0] q;

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                q <= '0;
            end else if (load_i && (addr == ADDR_W'(k))) begin
                q <= word_i[WORD_W-1:ADDR_W];
            end
        end

        if (k == 0) begin : g_ctl
            assign ctl_o = q;
        end else begin : g_aux
            assign aux_o[(k-1)*PAY_W +: PAY_W] = q;
        end
    end

endmodule

// File: rtl/pll_pd_seq.sv
module pll_pd_seq
    import pll_ctl_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  logic      wr_i,
    input  logic      req_i,
    input  logic      mode_i,
    input  logic      ref_div_i,
    input  logic      chip_en_i,
    output pd_state_t state_o,
    output logic      ref_edge_o,
    output logic      pd_o
);

    pd_state_t state;
    pd_state_t nxt;
    logic      ref_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ref_q <= 1'b0;
        end else begin
            ref_q <= ref_div_i;
        end
    end

    assign ref_edge_o = ref_div_i && !ref_q;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= PD_RUN;
        end else begin
            state <= nxt;
        end
    end

    // next state
    always_comb begin
        nxt = state;
        if (wr_i) begin
            if (!req_i) begin
                nxt = PD_RUN;
            end else if (!mode_i) begin
                nxt = PD_DOWN;
            end else if (state != PD_DOWN) begin
                nxt = PD_ARM1;
            end
        end else begin
            unique case (state)
                PD_RUN:  nxt = PD_RUN;
                PD_ARM1: if (ref_edge_o) nxt = PD_ARM2;
                PD_ARM2: if (ref_edge_o) nxt = PD_DOWN;
                PD_DOWN: nxt = PD_DOWN;
            endcase
        end
    end

    // outputs
    always_comb begin
        unique case (state)
            PD_DOWN: pd_o = 1'b1;
            PD_RUN, PD_ARM1, PD_ARM2: pd_o = !chip_en_i;
        endcase
    end

    assign state_o = state;

endmodule

// File: rtl/pll_ctl_top.sv
module pll_ctl_top
    import pll_ctl_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               ser_clk_i,
    input  logic               ser_dat_i,
    input  logic               ser_le_i,
    input  logic               chip_en_i,
    input  logic               ref_div_i,
    input  logic               lock_det_i,
    output logic [PRESC_W-1:0] presc_o,
    output logic [CS_W-1:0]    cp_cur_o,
    output logic               cp_tri_o,
    output logic               pdp_o,
    output logic [MUX_W-1:0]   mux_sel_o,
    output logic               cnt_rst_o,
    output logic               cnt_load_o,
    output logic               ld_rst_o,
    output logic               rf_en_o,
    output logic               pd_o,
    output logic [LVL_W-1:0]   out_pwr_o,
    output logic [LVL_W-1:0]   core_cur_o,
    output logic [AUX_W-1:0]   aux_regs_o
);

    localparam int O_PRESC = B_PRESC_LO - ADDR_W;
    localparam int O_CS2   = B_CS2_LO - ADDR_W;
    localparam int O_CS1   = B_CS1_LO - ADDR_W;
    localparam int O_OPWR  = B_OPWR_LO - ADDR_W;
    localparam int O_MUTE  = B_MUTE - ADDR_W;
    localparam int O_GAIN  = B_GAIN - ADDR_W;
    localparam int O_TRI   = B_TRI - ADDR_W;
    localparam int O_PDP   = B_PDP - ADDR_W;
    localparam int O_MUX   = B_MUX_LO - ADDR_W;
    localparam int O_CRST  = B_CRST - ADDR_W;
    localparam int O_CORE  = B_CORE_LO - ADDR_W;

    logic [WORD_W-1:0] rx_word;
    logic              rx_load;
    logic              ctl_wr;
    logic [PAY_W-1:0]  ctl_q;
    pd_state_t         pd_state;
    logic              ref_edge;
    logic              pd_act;

    pll_ser_rx #(
        .SYNC_STAGES (SYNC_STAGES)
    ) u_rx (
        .clk       (clk),
        .rst_n     (rst_n),
        .ser_clk_i (ser_clk_i),
        .ser_dat_i (ser_dat_i),
        .ser_le_i  (ser_le_i),
        .word_o    (rx_word),
        .load_o    (rx_load)
    );

    pll_reg_bank u_regs (
        .clk    (clk),
        .rst_n  (rst_n),
        .load_i (rx_load),
        .word_i (rx_word),
        .ctl_o  (ctl_q),
        .aux_o  (aux_regs_o)
    );

    assign ctl_wr = rx_load && (rx_word[ADDR_W-1:0] == '0);

    pll_pd_seq u_pd (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr_i       (ctl_wr),
        .req_i      (rx_word[B_PD_REQ]),
        .mode_i     (rx_word[B_PD_MODE]),
        .ref_div_i  (ref_div_i),
        .chip_en_i  (chip_en_i),
        .state_o    (pd_state),
        .ref_edge_o (ref_edge),
        .pd_o       (pd_act)
    );

    assign presc_o    = ctl_q[O_PRESC +: PRESC_W];
    assign cp_cur_o   = ctl_q[O_GAIN] ? ctl_q[O_CS2 +: CS_W] : ctl_q[O_CS1 +: CS_W];
    assign cp_tri_o   = ctl_q[O_TRI] || pd_act;
    assign pdp_o      = ctl_q[O_PDP];
    assign mux_sel_o  = ctl_q[O_MUX +: MUX_W];
    assign cnt_rst_o  = ctl_q[O_CRST];
    assign cnt_load_o = pd_act;
    assign ld_rst_o   = pd_act;
    assign rf_en_o    = !pd_act && (!ctl_q[O_MUTE] || lock_det_i);
    assign pd_o       = pd_act;
    assign out_pwr_o  = ctl_q[O_OPWR +: LVL_W];
    assign core_cur_o = ctl_q[O_CORE +: LVL_W];

endmodule

// File: rtl/pll_ctl_chk.sv
module pll_ctl_chk
    import pll_ctl_pkg::*;
(
    input logic             clk,
    input logic             rst_n,
    input logic             chip_en_i,
    input logic             lock_det_i,
    input logic             pd_o,
    input logic             rf_en_o,
    input logic             cp_tri_o,
    input logic             cnt_load_o,
    input logic             ld_rst_o,
    input pd_state_t        st,
    input logic             ctl_wr,
    input logic             wr_req,
    input logic             wr_mode,
    input logic             ref_edge,
    input logic [PAY_W-1:0] ctl_q
);

    // R7
    pd_side_chk: assert property (@(posedge clk) disable iff (!rst_n)
        pd_o |-> (!rf_en_o && cp_tri_o && cnt_load_o && ld_rst_o));

    // R6
    ce_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !chip_en_i |-> pd_o);

    // R3
    async_pd_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl_wr && wr_req && !wr_mode) |=> (st == PD_DOWN));

    // R4
    sync_arm_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl_wr && wr_req && wr_mode && st != PD_DOWN) |=> (st == PD_ARM1));

    // R4
    sync_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st == PD_ARM1 && ref_edge && !ctl_wr) |=> (st == PD_ARM2));

    // R5
    release_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl_wr && !wr_req) |=> (st == PD_RUN));

    // R9
    mute_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl_q[B_MUTE-ADDR_W] && !lock_det_i) |-> !rf_en_o);

    // R1
    hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !ctl_wr |=> $stable(ctl_q));

endmodule

bind pll_ctl_top pll_ctl_chk u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .chip_en_i  (chip_en_i),
    .lock_det_i (lock_det_i),
    .pd_o       (pd_o),
    .rf_en_o    (rf_en_o),
    .cp_tri_o   (cp_tri_o),
    .cnt_load_o (cnt_load_o),
    .ld_rst_o   (ld_rst_o),
    .st         (pd_state),
    .ctl_wr     (ctl_wr),
    .wr_req     (rx_word[20]),
    .wr_mode    (rx_word[21]),
    .ref_edge   (ref_edge),
    .ctl_q      (ctl_q)
);

// File: tb/tb_pll_ctl_top.sv
module tb_pll_ctl_top;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic ser_clk = 1'b0;
    logic ser_dat = 1'b0;
    logic ser_le = 1'b0;
    logic chip_en = 1'b1;
    logic ref_div = 1'b0;
    logic lock_det = 1'b0;

    logic [1:0]  presc;
    logic [2:0]  cp_cur;
    logic        cp_tri;
    logic        pdp;
    logic [2:0]  mux_sel;
    logic        cnt_rst;
    logic        cnt_load;
    logic        ld_rst;
    logic        rf_en;
    logic        pd;
    logic [1:0]  out_pwr;
    logic [1:0]  core_cur;
    logic [65:0] aux_regs;

    int nchk = 0;
    int nbad = 0;
    bit done = 1'b0;

    logic [23:0] ctl_m = '0;
    bit          down_m = 1'b0;
    logic [21:0] aux_m [1:3];

    always #2 clk = ~clk;

    pll_ctl_top dut (
        .clk        (clk),
        .rst_n      (rst_n),
        .ser_clk_i  (ser_clk),
        .ser_dat_i  (ser_dat),
        .ser_le_i   (ser_le),
        .chip_en_i  (chip_en),
        .ref_div_i  (ref_div),
        .lock_det_i (lock_det),
        .presc_o    (presc),
        .cp_cur_o   (cp_cur),
        .cp_tri_o   (cp_tri),
        .pdp_o      (pdp),
        .mux_sel_o  (mux_sel),
        .cnt_rst_o  (cnt_rst),
        .cnt_load_o (cnt_load),
        .ld_rst_o   (ld_rst),
        .rf_en_o    (rf_en),
        .pd_o       (pd),
        .out_pwr_o  (out_pwr),
        .core_cur_o (core_cur),
        .aux_regs_o (aux_regs)
    );

    function automatic logic [18:0] exp_vec(logic [23:0] w, bit down, bit ce, bit lk);
        bit pdx;
        logic [2:0] cur;
        pdx = down || !ce;
        cur = w[10] ? w[19:17] : w[16:14];
        return {w[23:22], cur, w[9] | pdx, w[8], w[7:5], w[4], pdx, pdx,
                !pdx && (!w[11] || lk), pdx, w[13:12], w[3:2]};
    endfunction

    function automatic logic [23:0] ctl_word(logic [1:0] pre, bit mode, bit req,
                                             logic [2:0] cs2, logic [2:0] cs1,
                                             logic [1:0] opw, bit mute, bit gain,
                                             bit tri3, bit pol, logic [2:0] mx,
                                             bit crst, logic [1:0] core);
        return {pre, mode, req, cs2, cs1, opw, mute, gain, tri3, pol, mx, crst, core, 2'b00};
    endfunction

    task automatic chk(string tag, logic [65:0] got, logic [65:0] exp);
        nchk++;
        if (got !== exp) begin
            nbad++;
            $display("FAIL %s got=%h exp=%h", tag, got, exp);
        end
    endtask

    task automatic check_all(string tag);
        chk(tag, 66'({presc, cp_cur, cp_tri, pdp, mux_sel, cnt_rst, cnt_load, ld_rst,
                      rf_en, pd, out_pwr, core_cur}),
            66'(exp_vec(ctl_m, down_m, chip_en, lock_det)));
        chk(tag, aux_regs, {aux_m[3], aux_m[2], aux_m[1]});
    endtask

    task automatic shift_bit(bit b);
        @(negedge clk);
        ser_dat = b;
        ser_clk = 1'b0;
        repeat (3) @(negedge clk);
        ser_clk = 1'b1;
        repeat (3) @(negedge clk);
        ser_clk = 1'b0;
    endtask

    task automatic send_word(logic [23:0] w, int extra);
        for (int i = 0; i < extra; i++) shift_bit(1'($urandom));
        for (int i = 23; i >= 0; i--) shift_bit(w[i]);
        @(negedge clk);
        ser_le = 1'b1;
        repeat (6) @(negedge clk);
        ser_le = 1'b0;
        repeat (3) @(negedge clk);
    endtask

    task automatic wr(logic [23:0] w, int extra);
        send_word(w, extra);
        if (w[1:0] == 2'b00) begin
            ctl_m = w;
            down_m = w[20] && (!w[21] || down_m);
        end else begin
            aux_m[w[1:0]] = w[23:2];
        end
    endtask

    task automatic pulse_ref();
        @(negedge clk);
        ref_div = 1'b1;
        @(negedge clk);
        ref_div = 1'b0;
        repeat (2) @(negedge clk);
    endtask

    initial begin
        logic [23:0] w;
        void'($urandom(32'h1F2E3D4C));
        aux_m[1] = '0;
        aux_m[2] = '0;
        aux_m[3] = '0;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        check_all("R1 reset state");

        // R2: leading junk bits are dropped
        w = ctl_word(2'b10, 0, 0, 3'b101, 3'b011, 2'b01, 0, 1, 0, 1, 3'b110, 0, 2'b10);
        wr(w, 7);
        check_all("R2 last 24 bits kept");
        check_all("R13 field decode");

        // R10: gain bit picks setting
        w = ctl_word(2'b01, 0, 0, 3'b111, 3'b010, 2'b10, 0, 0, 0, 0, 3'b001, 0, 2'b01);
        wr(w, 0);
        check_all("R10 gain=0 setting 1");
        w[10] = 1'b1;
        wr(w, 0);
        check_all("R10 gain=1 setting 2");

        // R11 and R12
        w = ctl_word(2'b11, 0, 0, 3'b000, 3'b100, 2'b11, 0, 0, 1, 0, 3'b010, 1, 2'b11);
        wr(w, 0);
        check_all("R11 R12 counter reset and three-state bit");

        // R1: routing of codes 1..3
        wr({22'h2A5A5A, 2'b01}, 0);
        wr({22'h15F0F0, 2'b10}, 0);
        wr({22'h3C3C3C, 2'b11}, 3);
        check_all("R1 address routing");

        // R3 asynchronous power-down, R7 side effects
        w = ctl_word(2'b00, 0, 1, 3'b001, 3'b010, 2'b00, 0, 0, 0, 1, 3'b011, 0, 2'b00);
        wr(w, 0);
        chk("R3 async power-down", 66'(pd), 66'(1));
        check_all("R7 side effects while down");

        // R8 serial port still loads while down
        wr({22'h0BEEF1, 2'b10}, 0);
        check_all("R8 load while powered down");

        // R5 release
        w[20] = 1'b0;
        wr(w, 0);
        chk("R5 release", 66'(pd), 66'(0));
        check_all("R5 outputs after release");

        // R4 synchronous power-down
        w[20] = 1'b1;
        w[21] = 1'b1;
        wr(w, 0);
        chk("R4 no power-down before edges", 66'(pd), 66'(0));
        pulse_ref();
        chk("R4 still up after one edge", 66'(pd), 66'(0));
        pulse_ref();
        down_m = 1'b1;
        chk("R4 down after second edge", 66'(pd), 66'(1));
        check_all("R4 R7 outputs after sync down");
        w[20] = 1'b0;
        w[21] = 1'b0;
        wr(w, 0);
        check_all("R5 release after sync");

        // R5 cancel pending synchronous request
        w[20] = 1'b1;
        w[21] = 1'b1;
        wr(w, 0);
        pulse_ref();
        w[20] = 1'b0;
        wr(w, 0);
        pulse_ref();
        pulse_ref();
        chk("R5 cancel pending sync", 66'(pd), 66'(0));

        // R6 chip enable override
        @(negedge clk);
        chip_en = 1'b0;
        @(negedge clk);
        chk("R6 chip enable low", 66'({pd, rf_en, cnt_load, cp_tri}), 66'(4'b1011));
        check_all("R6 outputs with chip enable low");
        chip_en = 1'b1;
        @(negedge clk);
        chk("R6 chip enable restored", 66'(pd), 66'(0));

        // R9 mute until lock
        w = ctl_word(2'b00, 0, 0, 3'b000, 3'b000, 2'b00, 1, 0, 0, 0, 3'b000, 0, 2'b00);
        lock_det = 1'b0;
        wr(w, 0);
        chk("R9 muted without lock", 66'(rf_en), 66'(0));
        lock_det = 1'b1;
        @(negedge clk);
        chk("R9 enabled with lock", 66'(rf_en), 66'(1));

        // random words
        for (int n = 0; n < 40; n++) begin
            w = 24'($urandom);
            if (w[1:0] == 2'b00 && w[20] && w[21] && !down_m) w[21] = 1'b0;
            chip_en = ($urandom % 8) != 0;
            lock_det = 1'($urandom);
            wr(w, int'($urandom % 4));
            check_all("R1 R13 random word");
        end

        done = 1'b1;
        $display("  test done: total=%0d bad=%0d", nchk, nbad);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            nchk++;
            nbad++;
            $display("FAIL watchdog expired");
            $display("  test done: total=%0d bad=%0d", nchk, nbad);
            $finish;
        end
    end

endmodule